// File: doc/BRIEF.md
# Flash Controller Configuration Write Guard

This block owns the control register, a small bank of timing/configuration registers and the status register of a flash controller. Its job is to keep those settings from being changed by a stray write. A protect flag in the control register blocks every write to the control and configuration registers while it is set. Each blocked write, and each attempt to flip the protect flag without permission, is dropped and latches a sticky error bit in the status register. Software clears that bit by writing a one to it.

The protect flag can change only through one control write that directly follows a three-write key sequence on two dedicated key registers. This applies whether the flag is being set or cleared. When protection is off, every other control bit and the configuration registers can be written freely. The protect flag keeps its value unless the key has just been given.

The bus is a single-cycle write port with an address, data and strobe, plus a read port. A read returns its data one cycle after the request. The flash operations and the program buffer sit outside this block.

Top module: `wpg_guard`

## Requirements
- R1: After reset the protect flag (control bit 1, control register at offset 0x00) is 1 and all other control bits are 0. The write-protect error (status bit 1, status register at offset 0x14) is 0. Every configuration register (offset 0x04 + 4*n, n < NUM_CFG) reads 0.
- R2: Key writes of 0x7123 to offset 0x18, then 0x812A to offset 0x1C, then 0xBEE1 to offset 0x18 open a window. In that window the next control write stores its full value, protect flag included, and raises no error.
- R3: A write with the wrong value, to the wrong key offset, or to any other address during the key sequence sends it back to the start. A fresh 0x7123 to offset 0x18 always restarts the sequence at its second step.
- R4: The open window is used up by the first write of any kind that follows it. A control write after that needs a new key sequence.
- R5: While the protect flag is 1 and no window is open, a write to the control register or to a configuration register leaves it unchanged and sets the error bit.
- R6: While the protect flag is 0 and no window is open, a control write stores all bits except bit 1, which keeps its value. If the written bit 1 differs from the flag, the error bit is set; otherwise the error bit is left alone.
- R7: While the protect flag is 0, configuration register writes take effect and raise no error.
- R8: The error bit is sticky. Writing status with bit 1 set clears it, and writing status with bit 1 clear leaves it set.
- R9: Writes to the key registers and the status register are never blocked by protection. The key registers and unmapped addresses read as 0.
- R10: A read request returns data with the read-valid strobe exactly one cycle later, and read-valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| wp_o | output | 1 | Current protect flag |
| err_o | output | 1 | Sticky write-protect error |

## Verification
The bench builds the guard with NUM_CFG set to 3 instead of the default 4. This turns offset 0x10 into an unmapped address, which makes two cases reachable: an unmapped read returns zero (R9), and a stray write to an unmapped offset in the middle of the key sequence breaks that sequence (R3). DATA_W stays at 32 and the keys keep their defaults. The bench therefore also checks that full-width data such as 0xDEADBEEF survives a configuration write.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    localparam int ADDR_W = 6;
    localparam int MAX_CFG = 4;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG0  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_KEY_A = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_KEY_B = 6'h1C;
    localparam int BIT_WP  = 1;
    localparam int BIT_ERR = 1;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_OPEN
    } key_stage_e;
endpackage

// File: rtl/wpg_key_seq.sv
module wpg_key_seq
    import wpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY1 = 'h7123,
    parameter logic [DATA_W-1:0] KEY2 = 'h812A,
    parameter logic [DATA_W-1:0] KEY3 = 'hBEE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              open_o
);
    typedef struct packed {
        key_stage_e stage;
    } ks_state_t;

    ks_state_t st_d, st_q;
    logic hit1, hit2, hit3;

    always_comb begin
        hit1 = wr_en && (wr_addr == OFS_KEY_A) && (wr_data == KEY1);
        hit2 = wr_en && (wr_addr == OFS_KEY_B) && (wr_data == KEY2);
        hit3 = wr_en && (wr_addr == OFS_KEY_A) && (wr_data == KEY3);
        st_d = st_q;
        if (wr_en) begin
            case (st_q.stage)
                KS_GOT1: st_d.stage = hit2 ? KS_GOT2 : (hit1 ? KS_GOT1 : KS_IDLE);
                KS_GOT2: st_d.stage = hit3 ? KS_OPEN : (hit1 ? KS_GOT1 : KS_IDLE);
                default: st_d.stage = hit1 ? KS_GOT1 : KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{stage: KS_IDLE};
        else        st_q <= st_d;
    end

    assign open_o = (st_q.stage == KS_OPEN);

    // R2: the window opens only on the third key at offset 0x18
    a_r2_open_on_third_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(wr_en && wr_addr == OFS_KEY_A && wr_data == KEY3));

    // R3: a wrong final step never opens the window
    a_r3_bad_step_no_open: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == KS_GOT2 && wr_en && !(wr_addr == OFS_KEY_A && wr_data == KEY3))
        |=> !open_o);

    // R4: any write closes an open window
    a_r4_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        $past(open_o && wr_en) |-> !open_o);
endmodule

// File: rtl/wpg_cfg_bank.sv
module wpg_cfg_bank
    import wpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CFG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_hit_o,
    output logic              wr_hit_o
);
    typedef struct packed {
        logic [NUM_CFG-1:0][DATA_W-1:0] regs;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [NUM_CFG-1:0] wsel, rsel;

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFS_I = ADDR_W'(OFS_CFG0 + 4 * i);
        assign wsel[i] = wr_en && (wr_addr == OFS_I);
        assign rsel[i] = (rd_addr == OFS_I);
    end

    assign wr_hit_o = |wsel;
    assign rd_hit_o = |rsel;

    always_comb begin
        st_d = st_q;
        rd_data_o = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (wsel[i] && !lock_i) st_d.regs[i] = wr_data;
            if (rsel[i]) rd_data_o = rd_data_o | st_q.regs[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a locked bank holds its contents
    a_r5_locked_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_i) |-> $stable(st_q.regs));
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
    import wpg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CFG = 4,
    parameter logic [DATA_W-1:0] KEY1 = 'h7123,
    parameter logic [DATA_W-1:0] KEY2 = 'h812A,
    parameter logic [DATA_W-1:0] KEY3 = 'hBEE1,
    parameter logic WP_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [5:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              wp_o,
    output logic              err_o
);
    localparam logic [DATA_W-1:0] CTRL_RESET = DATA_W'(WP_RESET) << BIT_WP;

    if (NUM_CFG < 1 || NUM_CFG > MAX_CFG) begin : g_bad_cfg
        $error("NUM_CFG out of range");
    end

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } top_state_t;

    top_state_t st_d, st_q;
    logic              key_open;
    logic [DATA_W-1:0] cfg_rd;
    logic              cfg_rd_hit, cfg_wr_hit;
    logic              ctrl_wr, stat_wr, violation;

    wpg_key_seq #(
        .DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .open_o(key_open)
    );

    wpg_cfg_bank #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock_i(st_q.ctrl[BIT_WP]), .rd_addr(rd_addr),
        .rd_data_o(cfg_rd), .rd_hit_o(cfg_rd_hit), .wr_hit_o(cfg_wr_hit)
    );

    always_comb begin
        st_d = st_q;
        ctrl_wr = wr_en && (wr_addr == OFS_CTRL);
        stat_wr = wr_en && (wr_addr == OFS_STAT);
        violation = 1'b0;

        if (ctrl_wr) begin
            if (key_open) begin
                st_d.ctrl = wr_data;
            end else if (st_q.ctrl[BIT_WP]) begin
                violation = 1'b1;
            end else begin
                st_d.ctrl = wr_data;
                st_d.ctrl[BIT_WP] = st_q.ctrl[BIT_WP];
                if (wr_data[BIT_WP] != st_q.ctrl[BIT_WP]) violation = 1'b1;
            end
        end
        if (cfg_wr_hit && st_q.ctrl[BIT_WP]) violation = 1'b1;

        if (stat_wr && wr_data[BIT_ERR]) st_d.err = 1'b0;
        if (violation)                   st_d.err = 1'b1;

        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.rdata = '0;
            if (rd_addr == OFS_CTRL)      st_d.rdata = st_q.ctrl;
            else if (rd_addr == OFS_STAT) st_d.rdata[BIT_ERR] = st_q.err;
            else if (cfg_rd_hit)          st_d.rdata = cfg_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl   <= CTRL_RESET;
            st_q.err    <= 1'b0;
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign rd_valid = st_q.rvalid;
    assign wp_o     = st_q.ctrl[BIT_WP];
    assign err_o    = st_q.err;

    // R2: the protect flag moves only through a keyed control write
    a_r2_wp_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_o) |-> $past(key_open && wr_en && wr_addr == OFS_CTRL));

    // R5: protected control register ignores unkeyed writes
    a_r5_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == OFS_CTRL && wp_o && !key_open) |-> $stable(st_q.ctrl));

    // R8: writing one to the error bit clears it
    a_r8_err_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_addr == OFS_STAT && wr_data[BIT_ERR]) |-> !err_o);

    // R8: the error bit rises only after a write
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(wr_en));

    // R10: read data valid exactly one cycle after the request
    a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_en));
endmodule

// File: tb/wpg_guard_bench.sv
module wpg_guard_bench;
    localparam int DW = 32;
    localparam logic [5:0] A_CTRL = 6'h00, A_CFG0 = 6'h04, A_CFG1 = 6'h08,
                           A_CFG2 = 6'h0C, A_HOLE = 6'h10, A_STAT = 6'h14,
                           A_KA = 6'h18, A_KB = 6'h1C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_valid, wp_o, err_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    wpg_guard #(.DATA_W(DW), .NUM_CFG(3)) u_wpg_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .wp_o(wp_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock();
        wr(A_KA, 32'h7123);
        wr(A_KB, 32'h812A);
        wr(A_KA, 32'hBEE1);
    endtask

    // monitor: pop expected read data as the design returns it (R10)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 actual=unexpected rd_valid expected=none");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wp", DW'(wp_o), 1);
        check("R1 err", DW'(err_o), 0);
        rd(A_CTRL, 32'h2, "R1 ctrl");
        rd(A_CFG0, 32'h0, "R1 cfg0");
        rd(A_STAT, 32'h0, "R1 stat");

        // R5 protected writes dropped, error raised
        wr(A_CFG1, 32'hAAAA);
        check("R5 err after cfg", DW'(err_o), 1);
        rd(A_CFG1, 32'h0, "R5 cfg1 unchanged");
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, 32'h2, "R5 ctrl unchanged");
        check("R5 wp held", DW'(wp_o), 1);

        // R8 sticky, W1C; R9 status writable under protection
        wr(A_STAT, 32'h0);
        check("R8 write zero keeps", DW'(err_o), 1);
        rd(A_STAT, 32'h2, "R8 stat read");
        wr(A_STAT, 32'h2);
        check("R8 R9 w1c clears", DW'(err_o), 0);

        // R2 unlock and clear protect
        unlock();
        wr(A_CTRL, 32'hF0);
        check("R2 wp cleared", DW'(wp_o), 0);
        check("R2 no err", DW'(err_o), 0);
        rd(A_CTRL, 32'hF0, "R2 ctrl value");

        // R7 configuration writes while unprotected
        wr(A_CFG1, 32'h1234);
        wr(A_CFG2, 32'hDEADBEEF);
        rd(A_CFG1, 32'h1234, "R7 cfg1");
        rd(A_CFG2, 32'hDEADBEEF, "R7 cfg2");
        check("R7 no err", DW'(err_o), 0);

        // R6 unkeyed control write while unprotected
        wr(A_CTRL, 32'h0F);
        rd(A_CTRL, 32'h0D, "R6 bit1 kept");
        check("R6 wp still 0", DW'(wp_o), 0);
        check("R6 err set", DW'(err_o), 1);
        wr(A_STAT, 32'h2);
        wr(A_CTRL, 32'h55);
        rd(A_CTRL, 32'h55, "R6 plain write");
        check("R6 no err", DW'(err_o), 0);

        // R4 window consumed by a non-control write
        unlock();
        wr(A_CFG0, 32'h11);
        wr(A_CTRL, 32'h02);
        check("R4 wp unchanged", DW'(wp_o), 0);
        check("R4 err", DW'(err_o), 1);
        rd(A_CTRL, 32'h0, "R4 ctrl");
        rd(A_CFG0, 32'h11, "R4 cfg0 written");
        wr(A_STAT, 32'h2);
        // R4 window consumed by a control write
        unlock();
        wr(A_CTRL, 32'h02);
        check("R4 wp set", DW'(wp_o), 1);
        wr(A_CTRL, 32'h00);
        check("R4 second write blocked", DW'(wp_o), 1);
        check("R4 second write err", DW'(err_o), 1);
        wr(A_STAT, 32'h2);
        check("R9 clear under protect", DW'(err_o), 0);

        // R3 wrong value
        wr(A_KA, 32'h7123); wr(A_KB, 32'h812B); wr(A_KA, 32'hBEE1);
        wr(A_CTRL, 32'h0);
        check("R3 wrong value", DW'(wp_o), 1);
        check("R3 wrong value err", DW'(err_o), 1);
        wr(A_STAT, 32'h2);
        // R3 wrong address
        wr(A_KA, 32'h7123); wr(A_KA, 32'h812A); wr(A_KA, 32'hBEE1);
        wr(A_CTRL, 32'h0);
        check("R3 wrong address", DW'(wp_o), 1);
        wr(A_STAT, 32'h2);
        // R3 restart with first key mid-sequence
        wr(A_KA, 32'h7123); wr(A_KB, 32'h812A); wr(A_KA, 32'h7123);
        wr(A_KB, 32'h812A); wr(A_KA, 32'hBEE1);
        wr(A_CTRL, 32'h0);
        check("R3 restart opens", DW'(wp_o), 0);
        check("R3 restart no err", DW'(err_o), 0);
        // R3 unmapped write inside the sequence
        wr(A_KA, 32'h7123); wr(A_HOLE, 32'h0); wr(A_KB, 32'h812A); wr(A_KA, 32'hBEE1);
        wr(A_CTRL, 32'h2);
        check("R3 stray write", DW'(wp_o), 0);
        check("R3 stray write err", DW'(err_o), 1);
        wr(A_STAT, 32'h2);

        // R9 key registers and unmapped offsets read zero
        rd(A_KA, 32'h0, "R9 key a");
        rd(A_KB, 32'h0, "R9 key b");
        rd(A_HOLE, 32'h0, "R9 unmapped");

        repeat (3) @(negedge clk);
        check("R10 queue drained", DW'(exp_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule